// File: doc/BRIEF.md
# Dual-Clock Programmable Almost-Flag Generator

This block drives the two programmable early-warning flags of a FIFO whose write side and read side run on unrelated clocks: an active-low almost-full flag and an active-low almost-empty flag. It receives the binary write pointer from the write domain and the binary read pointer from the read domain. Each pointer is one bit wider than the address, so that a full FIFO and an empty FIFO can be told apart. It also receives two quasi-static thresholds: the empty offset and the full offset. Each pointer crosses into the opposite domain as Gray code through a two-stage synchronizer. Each domain then computes its own view of the fill level and compares it against the thresholds.

A timing-select pin is captured while master reset is held. In synchronous timing, each flag lives entirely in one domain. The almost-full flag follows the write-side comparison on write-clock edges, and the almost-empty flag follows the read-side comparison on read-clock edges. In asynchronous timing, each flag is asserted by one clock and released by the other. This is built from a pair of toggle registers, one in each domain, whose exclusive-or is the flag. Each toggle is synchronized into the opposite domain, so neither side can move the flag twice.

Top module: `almost_flag_gen`

## Requirements
- R1: While master reset is held, almost_empty_n is 0 (asserted) and almost_full_n is 1 (deasserted).
- R2: timing_sel is captured only while mrst is high (1 = synchronous timing, 0 = asynchronous timing); changing it after reset has no effect on flag behaviour.
- R3: With fill count = (wr_ptr - rd_ptr) modulo 2^(AW+1), almost_empty_n settles to 0 when the count is at most empty_ofs, and to 1 otherwise.
- R4: almost_full_n settles to 0 when the count is at least 2^AW - full_ofs, and to 1 otherwise.
- R5: In synchronous timing, almost_full_n changes only on write-clock rising edges; one write-clock edge after the write side sees its count reach the threshold, the flag is 0.
- R6: In synchronous timing, almost_empty_n changes only on read-clock rising edges; with the read clock stopped it holds its value.
- R7: In asynchronous timing, almost_full_n is driven to 0 by the write clock and back to 1 by the read clock; it can rise while the write clock is stopped.
- R8: In asynchronous timing, almost_empty_n is driven to 0 by the read clock and back to 1 by the write clock; it can rise while the read clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, held for several cycles of both clocks |
| timing_sel | input | 1 | Flag timing select captured during reset: 1 synchronous, 0 asynchronous |
| wr_ptr | input | AW+1 | Binary write pointer with wrap bit, write-clock domain |
| rd_ptr | input | AW+1 | Binary read pointer with wrap bit, read-clock domain |
| empty_ofs | input | AW | Almost-empty threshold n |
| full_ofs | input | AW | Almost-full threshold m |
| almost_full_n | output | 1 | Almost-full flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |

## Verification
The assertions assume that mrst is held across several edges of both clocks and that timing_sel is steady for that whole time. They also assume that each pointer moves by at most one per edge of its own clock and is zero while reset is held. The stimulus walks each pointer one step per edge, and orders the two pointers so that the fill count stays between 0 and the depth. It changes the thresholds only between settled phases, and it stops one clock at a time to show which domain moves each flag.

// File: rtl/afg_pkg.sv
package afg_pkg;
  typedef enum logic {
    TM_ASYNC = 1'b0,
    TM_SYNC  = 1'b1
  } timing_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/afg_ptr_xfer.sv
// Carries a binary pointer from one clock domain into another as Gray code.
module afg_ptr_xfer #(
  parameter int unsigned W      = 11,
  parameter int unsigned STAGES = afg_pkg::SYNC_STAGES
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst,
  input  logic [W-1:0] src_bin,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] gray_q;
  logic [W-1:0] chain_q [STAGES];

  // Registered Gray encode in the source domain: one bit changes per step.
  always_ff @(posedge src_clk) begin
    if (rst) gray_q <= '0;
    else     gray_q <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= gray_q;
      for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
    end
  end

  // Gray to binary: each bit is the parity of itself and all higher bits.
  for (genvar b = 0; b < int'(W); b++) begin : g_dec
    assign dst_bin[b] = ^(chain_q[STAGES-1] >> b);
  end
endmodule

// File: rtl/afg_level_cmp.sv
// Fill-level threshold compare for one domain's view of the two pointers.
module afg_level_cmp #(
  parameter int unsigned AW = 10
) (
  input  logic [AW:0]   wr_ptr,
  input  logic [AW:0]   rd_ptr,
  input  logic [AW-1:0] empty_ofs,
  input  logic [AW-1:0] full_ofs,
  output logic          near_empty,
  output logic          near_full
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1) << AW;

  logic [PW-1:0] count;
  logic [PW-1:0] full_thr;

  always_comb begin
    count      = wr_ptr - rd_ptr;
    full_thr   = DEPTH - {1'b0, full_ofs};
    near_empty = (count <= {1'b0, empty_ofs});
    near_full  = (count >= full_thr);
  end
endmodule

// File: rtl/afg_flag_cell.sv
// One active-low flag. Synchronous timing: level register in the set domain.
// Asynchronous timing: set toggle in the set domain, clear toggle in the
// clear domain; the flag is asserted while the toggles differ.
module afg_flag_cell
  import afg_pkg::*;
#(
  parameter logic RST_ON = 1'b0
) (
  input  logic    clk_s,
  input  logic    clk_c,
  input  logic    rst,
  input  timing_e mode_s,
  input  logic    set_hit,
  input  logic    clr_hit,
  output logic    flag_n
);
  localparam int unsigned NS = SYNC_STAGES;

  logic          lvl_q;
  logic          tog_s_q;
  logic          tog_c_q;
  logic [NS-1:0] c_in_s_q;
  logic [NS-1:0] s_in_c_q;
  logic          on_view_s;
  logic          on_view_c;

  always_ff @(posedge clk_s) begin
    if (rst) lvl_q <= RST_ON;
    else     lvl_q <= set_hit;
  end

  assign on_view_s = tog_s_q ^ c_in_s_q[NS-1];
  assign on_view_c = s_in_c_q[NS-1] ^ tog_c_q;

  always_ff @(posedge clk_s) begin
    if (rst) begin
      tog_s_q  <= RST_ON;
      c_in_s_q <= '0;
    end else begin
      c_in_s_q <= {c_in_s_q[NS-2:0], tog_c_q};
      if (!on_view_s && set_hit) tog_s_q <= ~tog_s_q;
    end
  end

  always_ff @(posedge clk_c) begin
    if (rst) begin
      tog_c_q  <= 1'b0;
      s_in_c_q <= {NS{RST_ON}};
    end else begin
      s_in_c_q <= {s_in_c_q[NS-2:0], tog_s_q};
      if (on_view_c && clr_hit) tog_c_q <= ~tog_c_q;
    end
  end

  // Select is static after reset; only one toggle moves at a time.
  assign flag_n = (mode_s == TM_SYNC) ? ~lvl_q : ~(tog_s_q ^ tog_c_q);
endmodule

// File: rtl/almost_flag_gen.sv
module almost_flag_gen
  import afg_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst,
  input  logic          timing_sel,
  input  logic [AW:0]   wr_ptr,
  input  logic [AW:0]   rd_ptr,
  input  logic [AW-1:0] empty_ofs,
  input  logic [AW-1:0] full_ofs,
  output logic          almost_full_n,
  output logic          almost_empty_n
);
  localparam int unsigned PW = AW + 1;

  timing_e       mode_w;
  timing_e       mode_r;
  logic [PW-1:0] rd_ptr_w;
  logic [PW-1:0] wr_ptr_r;
  logic          ne_w, nf_w, ne_r, nf_r;

  always_ff @(posedge wr_clk) begin
    if (mrst) mode_w <= timing_e'(timing_sel);
  end

  always_ff @(posedge rd_clk) begin
    if (mrst) mode_r <= timing_e'(timing_sel);
  end

  afg_ptr_xfer #(.W(PW)) i_rd_to_wr (
    .src_clk(rd_clk), .dst_clk(wr_clk), .rst(mrst),
    .src_bin(rd_ptr), .dst_bin(rd_ptr_w)
  );

  afg_ptr_xfer #(.W(PW)) i_wr_to_rd (
    .src_clk(wr_clk), .dst_clk(rd_clk), .rst(mrst),
    .src_bin(wr_ptr), .dst_bin(wr_ptr_r)
  );

  afg_level_cmp #(.AW(AW)) i_cmp_w (
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr_w),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .near_empty(ne_w), .near_full(nf_w)
  );

  afg_level_cmp #(.AW(AW)) i_cmp_r (
    .wr_ptr(wr_ptr_r), .rd_ptr(rd_ptr),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .near_empty(ne_r), .near_full(nf_r)
  );

  afg_flag_cell #(.RST_ON(1'b0)) i_full_flag (
    .clk_s(wr_clk), .clk_c(rd_clk), .rst(mrst), .mode_s(mode_w),
    .set_hit(nf_w), .clr_hit(!nf_r), .flag_n(almost_full_n)
  );

  afg_flag_cell #(.RST_ON(1'b1)) i_empty_flag (
    .clk_s(rd_clk), .clk_c(wr_clk), .rst(mrst), .mode_s(mode_r),
    .set_hit(ne_r), .clr_hit(!ne_w), .flag_n(almost_empty_n)
  );
endmodule

// File: rtl/afg_flags_chk.sv
module afg_flags_chk
  import afg_pkg::*;
(
  input logic    wr_clk,
  input logic    rd_clk,
  input logic    mrst,
  input timing_e mode_w,
  input timing_e mode_r,
  input logic    nf_w,
  input logic    ne_r,
  input logic    almost_full_n,
  input logic    almost_empty_n
);
  // R1
  reset_wr_view_chk: assert property (@(posedge wr_clk)
    $fell(mrst) |-> (almost_full_n && !almost_empty_n));

  // R1
  reset_rd_view_chk: assert property (@(posedge rd_clk)
    $fell(mrst) |-> (almost_full_n && !almost_empty_n));

  // R2
  mode_agree_chk: assert property (@(posedge wr_clk) disable iff (mrst)
    mode_w == mode_r);

  // R5
  sync_full_set_chk: assert property (@(posedge wr_clk) disable iff (mrst)
    (mode_w == TM_SYNC && nf_w) |=> !almost_full_n);

  // R5
  sync_full_clr_chk: assert property (@(posedge wr_clk) disable iff (mrst)
    (mode_w == TM_SYNC && !nf_w) |=> almost_full_n);

  // R6
  sync_empty_set_chk: assert property (@(posedge rd_clk) disable iff (mrst)
    (mode_r == TM_SYNC && ne_r) |=> !almost_empty_n);

  // R6
  sync_empty_clr_chk: assert property (@(posedge rd_clk) disable iff (mrst)
    (mode_r == TM_SYNC && !ne_r) |=> almost_empty_n);
endmodule

bind almost_flag_gen afg_flags_chk i_flags_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst),
  .mode_w(mode_w), .mode_r(mode_r), .nf_w(nf_w), .ne_r(ne_r),
  .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
);

// File: tb/test_almost_flag_gen.sv
`timescale 1ns/100ps
module test_almost_flag_gen;
  localparam int AW    = 4;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  // {wr_ptr[5], rd_ptr[5], empty_ofs[4], full_ofs[4], exp_full_n, exp_empty_n}
  localparam logic [19:0] VEC [12] = '{
    {5'd0,  5'd0,  4'd2, 4'd3,  1'b1, 1'b0},
    {5'd3,  5'd0,  4'd2, 4'd3,  1'b1, 1'b1},
    {5'd13, 5'd0,  4'd2, 4'd3,  1'b0, 1'b1},
    {5'd16, 5'd0,  4'd2, 4'd3,  1'b0, 1'b1},
    {5'd20, 5'd6,  4'd2, 4'd3,  1'b0, 1'b1},
    {5'd20, 5'd18, 4'd2, 4'd3,  1'b1, 1'b0},
    {5'd20, 5'd18, 4'd1, 4'd3,  1'b1, 1'b1},
    {5'd25, 5'd20, 4'd5, 4'd3,  1'b1, 1'b0},
    {5'd4,  5'd22, 4'd5, 4'd2,  1'b0, 1'b1},
    {5'd4,  5'd30, 4'd6, 4'd0,  1'b1, 1'b0},
    {5'd4,  5'd4,  4'd0, 4'd15, 1'b1, 1'b0},
    {5'd5,  5'd4,  4'd0, 4'd15, 1'b0, 1'b1}
  };

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic w_run = 1'b1, r_run = 1'b1;
  logic mrst = 1'b1, timing_sel = 1'b1;
  logic [PW-1:0] wr_ptr = '0, rd_ptr = '0;
  logic [AW-1:0] empty_ofs = '0, full_ofs = '0;
  logic almost_full_n, almost_empty_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always begin #4;   if (w_run || wr_clk) wr_clk = ~wr_clk; end
  always begin #5.5; if (r_run || rd_clk) rd_clk = ~rd_clk; end

  almost_flag_gen #(.AW(AW)) i_almost_flag_gen (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .timing_sel(timing_sel),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
  );

  task automatic check(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic settle_both(); repeat (12) @(posedge rd_clk); #1; endtask
  task automatic settle_w();    repeat (12) @(posedge wr_clk); #1; endtask
  task automatic settle_r();    repeat (12) @(posedge rd_clk); #1; endtask

  task automatic stop_w(); w_run = 1'b0; if (wr_clk) @(negedge wr_clk); #1; endtask
  task automatic stop_r(); r_run = 1'b0; if (rd_clk) @(negedge rd_clk); #1; endtask

  task automatic step_w(input logic [PW-1:0] tgt);
    while (wr_ptr != tgt) begin @(negedge wr_clk); wr_ptr = wr_ptr + 1'b1; end
  endtask

  task automatic step_r(input logic [PW-1:0] tgt);
    while (rd_ptr != tgt) begin @(negedge rd_clk); rd_ptr = rd_ptr + 1'b1; end
  endtask

  // Keep the fill count within 0..DEPTH while moving both pointers.
  task automatic move(input logic [PW-1:0] w, input logic [PW-1:0] r);
    logic [PW-1:0] d;
    d = w - rd_ptr;
    if (d <= PW'(DEPTH)) begin step_w(w); step_r(r); end
    else                 begin step_r(r); step_w(w); end
  endtask

  task automatic set_ofs(input logic [AW-1:0] n, input logic [AW-1:0] m);
    @(negedge wr_clk); empty_ofs = n; full_ofs = m;
  endtask

  task automatic do_reset(input logic sy);
    @(negedge wr_clk);
    mrst = 1'b1; timing_sel = sy; wr_ptr = '0; rd_ptr = '0;
    repeat (4) @(posedge rd_clk); #1;
    check("R1 full flag in reset", almost_full_n, 1'b1);
    check("R1 empty flag in reset", almost_empty_n, 1'b0);
    @(negedge wr_clk); mrst = 1'b0;
  endtask

  task automatic run_table(input logic sy);
    for (int i = 0; i < 12; i++) begin
      set_ofs(VEC[i][9:6], VEC[i][5:2]);
      move(VEC[i][19:15], VEC[i][14:10]);
      settle_both();
      check($sformatf("R4 vec %0d mode %0d full", i, sy), almost_full_n, VEC[i][1]);
      check($sformatf("R3 vec %0d mode %0d empty", i, sy), almost_empty_n, VEC[i][0]);
    end
  endtask

  // Starts from pointers (5,4); thresholds n=2, m=3 (full threshold 13).
  task automatic directed(input logic sy);
    string lf, le;
    lf = sy ? "R5" : "R7";
    le = sy ? "R6" : "R8";
    set_ofs(4'd2, 4'd3);
    move(5'd20, 5'd4);
    settle_both();
    check("R4 count 16 full", almost_full_n, 1'b0);
    @(negedge wr_clk); timing_sel = ~sy;               // R2: ignored after reset
    stop_w(); step_r(5'd14); settle_r();               // count 6, write clock stopped
    check({lf, " R2 full with write clock stopped"}, almost_full_n, sy ? 1'b0 : 1'b1);
    w_run = 1'b1; settle_both();
    check({lf, " full after restart"}, almost_full_n, 1'b1);
    check("R3 count 6 empty", almost_empty_n, 1'b1);
    step_r(5'd19); settle_both();                      // count 1
    check("R3 count 1 empty", almost_empty_n, 1'b0);
    stop_r(); step_w(5'd25); settle_w();               // count 6, read clock stopped
    check({le, " empty with read clock stopped"}, almost_empty_n, sy ? 1'b0 : 1'b1);
    step_w(5'd0); settle_w();                          // count 13
    check({lf, " full set by write clock"}, almost_full_n, 1'b0);
    r_run = 1'b1; settle_both();
    check({le, " empty after restart"}, almost_empty_n, 1'b1);
    stop_w(); step_r(5'd30); settle_r();               // count 2, write clock stopped
    check({le, " empty set by read clock"}, almost_empty_n, 1'b0);
    check({lf, " full with write clock stopped, low count"}, almost_full_n, sy ? 1'b0 : 1'b1);
    w_run = 1'b1; settle_both();
    check({lf, " full settled at count 2"}, almost_full_n, 1'b1);
    check("R3 empty settled at count 2", almost_empty_n, 1'b0);
  endtask

  initial begin
    do_reset(1'b1);
    run_table(1'b1);
    move(5'd5, 5'd4);
    directed(1'b1);
    do_reset(1'b0);
    run_table(1'b0);
    directed(1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule